// File: doc/BRIEF.md
# Command List Header Decoder

This block turns a stream of 32-bit command-list words into register-write transactions. A list starts with a one-cycle start pulse that carries the list length in words. The words then arrive on a valid/ready channel. Each header word names a target register (the method), a subchannel, a count and a submission mode. The words that follow a header are its arguments, and the mode decides which method each argument goes to. An inline header carries its only value inside the header, so no argument words follow it.

Every write leaves through a one-entry output slot with a valid/ready handshake. A downstream engine that holds ready low stalls word intake, and no write is lost. Two single-cycle error pulses report a header with an unused mode code and a header whose arguments run past the end of the list. Parsing ends once the stated number of words has been consumed.

Top module: `pb_cmd_decoder`

## Requirements
- R1: After reset, `busy`, `wordReady`, `wrValid`, `errBadMode` and `errTrunc` are all low.
- R2: A header word is split as follows: method in bits 12:0, subchannel in bits 15:13, count in bits 28:16, mode in bits 31:29. Every write carries the subchannel of the header it came from.
- R3: In modes 0 and 1, argument i (counting from 0) is written to method + i, modulo 2^13.
- R4: In modes 2 and 3, every argument is written to the header's method.
- R5: In mode 5, the first argument goes to the method and every later argument goes to method + 1, modulo 2^13. A mode-5 header with count 0 produces no write, and the next word is treated as a header.
- R6: Mode 4 produces exactly one write. Its method and subchannel come from the header, and its value is bits 28:16 of the header, zero-extended. The next word is treated as a header.
- R7: A start pulse with length N seen while `busy` is low makes the block consume exactly N words and then drop `busy` and `wordReady`. A length of 0 leaves the block idle. A start pulse while `busy` is high is ignored.
- R8: A header with mode 6 or 7 produces no write. It pulses `errBadMode` for one cycle, the cycle after the header is accepted, and the next word is treated as a header.
- R9: When a header's count exceeds the words left in the list after it, every remaining word is written as an argument. `errTrunc` pulses for one cycle, the cycle after the header is accepted, and the list ends.
- R10: While `wrValid` is high and `wrReady` is low, the write's method, subchannel and value stay stable and `wordReady` is low.
- R11: A write appears on `wrValid` in the cycle after the word that produces it is accepted. An accepted word that produces no write leaves `wrValid` low in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| listStart | input | 1 | Start pulse for a new list; taken only while idle |
| listLen | input | LEN_W | Length of the new list in words |
| wordValid | input | 1 | Command word available |
| wordReady | output | 1 | Block accepts a word this cycle |
| wordData | input | 32 | Command word |
| wrValid | output | 1 | Register write pending |
| wrReady | input | 1 | Downstream takes the pending write |
| wrMethod | output | 13 | Target method of the write |
| wrSubch | output | 3 | Subchannel of the write |
| wrValue | output | 32 | Data of the write |
| busy | output | 1 | A list is being parsed |
| errBadMode | output | 1 | One-cycle pulse: header had mode 6 or 7 |
| errTrunc | output | 1 | One-cycle pulse: header's arguments exceed the list |

## Verification
The output slot can be drained by `wrReady` in the same cycle that a new argument or inline header refills it. A header-phase decision (error, truncation, end of list) can also coincide with the drain of the previous write. The bench provokes both by driving `wordValid` and `wrReady` from independent random draws at several duty ratios. It judges the result in two ways: every handshaken write must match the next entry of a model-built list in order, and after each accepted word `wrValid` and the two error pulses must match that word's own expected effect.

// File: rtl/pbdec_pkg.sv
package pbdec_pkg;
  localparam int WORD_W   = 32;
  localparam int METHOD_W = 13;
  localparam int SUBCH_W  = 3;
  localparam int COUNT_W  = 13;
  localparam int MODE_W   = 3;
  localparam int SUBCH_LSB = METHOD_W;
  localparam int COUNT_LSB = SUBCH_LSB + SUBCH_W;
  localparam int MODE_LSB  = COUNT_LSB + COUNT_W;

  typedef enum logic [MODE_W-1:0] {
    MODE_INC_OLD = 3'd0,
    MODE_INC     = 3'd1,
    MODE_FIX_OLD = 3'd2,
    MODE_FIX     = 3'd3,
    MODE_IMM     = 3'd4,
    MODE_ONCE    = 3'd5,
    MODE_BAD6    = 3'd6,
    MODE_BAD7    = 3'd7
  } modeT;

  // packed MSB first: mode | count | subchannel | method
  typedef struct packed {
    modeT                mode;
    logic [COUNT_W-1:0]  count;
    logic [SUBCH_W-1:0]  subch;
    logic [METHOD_W-1:0] method;
  } hdrT;

  typedef struct packed {
    logic loadHdr;  // latch header fields for an argument run
    logic loadArg;  // place an argument word in the output slot
    logic loadImm;  // place an inline header's value in the output slot
  } strobeT;
endpackage

// File: rtl/pbdec_ctrl.sv
module pbdec_ctrl
  import pbdec_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               listStart,
  input  logic [LEN_W-1:0]   listLen,
  input  logic               wordValid,
  input  modeT               hdrMode,
  input  logic [COUNT_W-1:0] hdrCount,
  input  logic               slotFree,
  output logic               wordReady,
  output logic               busy,
  output strobeT             strobe,
  output logic               errBadMode,
  output logic               errTrunc
);
  localparam int CMP_W = (LEN_W > COUNT_W) ? LEN_W : COUNT_W;

  typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_ARG} phaseT;

  phaseT            phase;
  logic [LEN_W-1:0] wordsLeft;
  logic [LEN_W-1:0] argsLeft;

  logic             accept;
  logic [LEN_W-1:0] wordsAfter;
  logic             overrun;
  logic [LEN_W-1:0] takeArgs;
  logic             isBad;
  logic             isImm;
  logic             isRun;

  assign wordReady  = (phase != PH_IDLE) && slotFree;
  assign busy       = (phase != PH_IDLE);
  assign accept     = wordReady && wordValid;
  assign wordsAfter = wordsLeft - 1'b1;
  assign overrun    = CMP_W'(hdrCount) > CMP_W'(wordsAfter);
  assign takeArgs   = overrun ? wordsAfter : LEN_W'(hdrCount);
  assign isBad      = (hdrMode == MODE_BAD6) || (hdrMode == MODE_BAD7);
  assign isImm      = (hdrMode == MODE_IMM);
  assign isRun      = !isBad && !isImm;

  always_comb begin
    strobe         = '0;
    strobe.loadHdr = accept && (phase == PH_HDR) && isRun;
    strobe.loadImm = accept && (phase == PH_HDR) && isImm;
    strobe.loadArg = accept && (phase == PH_ARG);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase      <= PH_IDLE;
      wordsLeft  <= '0;
      argsLeft   <= '0;
      errBadMode <= 1'b0;
      errTrunc   <= 1'b0;
    end else begin
      errBadMode <= 1'b0;
      errTrunc   <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (listStart && (listLen != '0)) begin
            phase     <= PH_HDR;
            wordsLeft <= listLen;
          end
        end
        PH_HDR: begin
          if (accept) begin
            wordsLeft <= wordsAfter;
            if (isBad) errBadMode <= 1'b1;
            if (isRun) begin
              argsLeft <= takeArgs;
              errTrunc <= overrun;
            end
            if (wordsAfter == '0)                  phase <= PH_IDLE;
            else if (isRun && (takeArgs != '0))    phase <= PH_ARG;
            else                                   phase <= PH_HDR;
          end
        end
        PH_ARG: begin
          if (accept) begin
            wordsLeft <= wordsAfter;
            argsLeft  <= argsLeft - 1'b1;
            if (wordsAfter == '0)                  phase <= PH_IDLE;
            else if (argsLeft == LEN_W'(1))        phase <= PH_HDR;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pbdec_dp.sv
module pbdec_dp
  import pbdec_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  strobeT              strobe,
  input  logic [WORD_W-1:0]   wordData,
  input  logic                wrReady,
  output logic                slotFree,
  output logic                wrValid,
  output logic [METHOD_W-1:0] wrMethod,
  output logic [SUBCH_W-1:0]  wrSubch,
  output logic [WORD_W-1:0]   wrValue
);
  hdrT                 hdr;
  logic [METHOD_W-1:0] baseMethod;
  logic [SUBCH_W-1:0]  curSubch;
  modeT                curMode;
  logic [METHOD_W-1:0] argIdx;
  logic [METHOD_W-1:0] argMethod;

  assign hdr      = hdrT'(wordData);
  assign slotFree = !wrValid || wrReady;

  always_comb begin
    case (curMode)
      MODE_FIX_OLD, MODE_FIX: argMethod = baseMethod;
      MODE_ONCE:              argMethod = (argIdx == '0) ? baseMethod : baseMethod + 1'b1;
      default:                argMethod = baseMethod + argIdx;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseMethod <= '0;
      curSubch   <= '0;
      curMode    <= MODE_INC;
      argIdx     <= '0;
      wrValid    <= 1'b0;
      wrMethod   <= '0;
      wrSubch    <= '0;
      wrValue    <= '0;
    end else begin
      if (strobe.loadHdr) begin
        baseMethod <= hdr.method;
        curSubch   <= hdr.subch;
        curMode    <= hdr.mode;
        argIdx     <= '0;
      end
      if (strobe.loadArg) begin
        wrValid  <= 1'b1;
        wrMethod <= argMethod;
        wrSubch  <= curSubch;
        wrValue  <= wordData;
        argIdx   <= argIdx + 1'b1;
      end else if (strobe.loadImm) begin
        wrValid  <= 1'b1;
        wrMethod <= hdr.method;
        wrSubch  <= hdr.subch;
        wrValue  <= WORD_W'(hdr.count);
      end else if (wrReady) begin
        wrValid  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pb_cmd_decoder.sv
module pb_cmd_decoder
  import pbdec_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                listStart,
  input  logic [LEN_W-1:0]    listLen,
  input  logic                wordValid,
  output logic                wordReady,
  input  logic [WORD_W-1:0]   wordData,
  output logic                wrValid,
  input  logic                wrReady,
  output logic [METHOD_W-1:0] wrMethod,
  output logic [SUBCH_W-1:0]  wrSubch,
  output logic [WORD_W-1:0]   wrValue,
  output logic                busy,
  output logic                errBadMode,
  output logic                errTrunc
);
  strobeT strobe;
  logic   slotFree;

  pbdec_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .listStart  (listStart),
    .listLen    (listLen),
    .wordValid  (wordValid),
    .hdrMode    (modeT'(wordData[MODE_LSB +: MODE_W])),
    .hdrCount   (wordData[COUNT_LSB +: COUNT_W]),
    .slotFree   (slotFree),
    .wordReady  (wordReady),
    .busy       (busy),
    .strobe     (strobe),
    .errBadMode (errBadMode),
    .errTrunc   (errTrunc)
  );

  pbdec_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wordData (wordData),
    .wrReady  (wrReady),
    .slotFree (slotFree),
    .wrValid  (wrValid),
    .wrMethod (wrMethod),
    .wrSubch  (wrSubch),
    .wrValue  (wrValue)
  );
endmodule

// File: rtl/pbdec_checker.sv
module pbdec_checker
  import pbdec_pkg::*;
(
  input logic                clk,
  input logic                rstN,
  input logic                wordValid,
  input logic                wordReady,
  input logic                wrValid,
  input logic                wrReady,
  input logic [METHOD_W-1:0] wrMethod,
  input logic [SUBCH_W-1:0]  wrSubch,
  input logic [WORD_W-1:0]   wrValue,
  input logic                busy,
  input logic                errBadMode,
  input logic                errTrunc
);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |=> (wrValid && $stable(wrMethod) && $stable(wrSubch) && $stable(wrValue)));

  assert_stall_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrReady) |-> !wordReady);

  assert_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wordReady);

  assert_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wrValid) |-> $past(wordValid && wordReady));

  assert_badnowrite_R8: assert property (@(posedge clk) disable iff (!rstN)
    errBadMode |-> (!wrValid && $past(wordValid && wordReady)));

  assert_trunc_R9: assert property (@(posedge clk) disable iff (!rstN)
    errTrunc |-> $past(wordValid && wordReady));

  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(errBadMode && errTrunc));
endmodule

bind pb_cmd_decoder pbdec_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wordValid  (wordValid),
  .wordReady  (wordReady),
  .wrValid    (wrValid),
  .wrReady    (wrReady),
  .wrMethod   (wrMethod),
  .wrSubch    (wrSubch),
  .wrValue    (wrValue),
  .busy       (busy),
  .errBadMode (errBadMode),
  .errTrunc   (errTrunc)
);

// File: tb/sim_pb_cmd_decoder.sv
`timescale 1ns/1ps
module sim_pb_cmd_decoder;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        listStart = 1'b0;
  logic [15:0] listLen = '0;
  logic        wordValid = 1'b0;
  logic        wordReady;
  logic [31:0] wordData = '0;
  logic        wrValid;
  logic        wrReady = 1'b0;
  logic [12:0] wrMethod;
  logic [2:0]  wrSubch;
  logic [31:0] wrValue;
  logic        busy;
  logic        errBadMode;
  logic        errTrunc;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pb_cmd_decoder #(.LEN_W(16)) u0 (
    .clk(clk), .rstN(rstN), .listStart(listStart), .listLen(listLen),
    .wordValid(wordValid), .wordReady(wordReady), .wordData(wordData),
    .wrValid(wrValid), .wrReady(wrReady), .wrMethod(wrMethod), .wrSubch(wrSubch),
    .wrValue(wrValue), .busy(busy), .errBadMode(errBadMode), .errTrunc(errTrunc)
  );

  logic [31:0] mem     [0:63];
  bit          expProd [0:63];
  bit          expBad  [0:63];
  bit          expTrunc[0:63];
  logic [12:0] eMethod [0:63];
  logic [2:0]  eSubch  [0:63];
  logic [31:0] eValue  [0:63];
  string       eTag    [0:63];
  int          nExp;

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkHdr(input int mode, input int cnt, input int sub, input int meth);
    return {mode[2:0], cnt[12:0], sub[2:0], meth[12:0]};
  endfunction

  // Reference model built from the requirements
  task automatic buildModel(input int len);
    int pos = 0;
    nExp = 0;
    for (int i = 0; i < 64; i++) begin
      expProd[i] = 0; expBad[i] = 0; expTrunc[i] = 0;
    end
    while (pos < len) begin
      logic [31:0] h = mem[pos];
      int mode = int'(h[31:29]);
      int cnt  = int'(h[28:16]);
      logic [2:0]  sub  = h[15:13];
      logic [12:0] meth = h[12:0];
      if (mode >= 6) begin
        expBad[pos] = 1; pos++;
      end else if (mode == 4) begin
        expProd[pos] = 1;
        eMethod[nExp] = meth; eSubch[nExp] = sub; eValue[nExp] = {19'd0, h[28:16]};
        eTag[nExp] = "R6"; nExp++; pos++;
      end else begin
        int avail = len - pos - 1;
        int take  = (cnt > avail) ? avail : cnt;
        expTrunc[pos] = (cnt > avail);
        pos++;
        for (int i = 0; i < take; i++) begin
          expProd[pos] = 1;
          eSubch[nExp] = sub; eValue[nExp] = mem[pos];
          if (mode <= 1) begin
            eMethod[nExp] = meth + 13'(i); eTag[nExp] = "R3";
          end else if (mode <= 3) begin
            eMethod[nExp] = meth; eTag[nExp] = "R4";
          end else begin
            eMethod[nExp] = (i == 0) ? meth : meth + 13'd1; eTag[nExp] = "R5";
          end
          nExp++; pos++;
        end
      end
    end
  endtask

  task automatic runList(input int len, input int validPct, input int readyPct, input bit poke);
    int idx = 0, got = 0, cyc = 0, pendIdx = 0;
    bit pendAcc = 0, held = 0;
    logic [12:0] hM; logic [2:0] hS; logic [31:0] hV;
    buildModel(len);
    listStart = 1'b1; listLen = 16'(len);
    @(posedge clk); #1;
    listStart = 1'b0;
    while (!(idx == len && got == nExp && !busy && !pendAcc) && cyc < 5000) begin
      wordValid = (idx < len) && (($urandom % 100) < validPct);
      wordData  = wordValid ? mem[idx] : $urandom;
      wrReady   = (($urandom % 100) < readyPct);
      if (poke && cyc == 3) begin listStart = 1'b1; listLen = 16'd1; end
      else listStart = 1'b0;
      @(negedge clk);
      if (pendAcc) begin
        check(wrValid == expProd[pendIdx], "R11", "wrValid after accepted word", wrValid, expProd[pendIdx]);
        check(errBadMode == expBad[pendIdx], "R8", "errBadMode pulse", errBadMode, expBad[pendIdx]);
        check(errTrunc == expTrunc[pendIdx], "R9", "errTrunc pulse", errTrunc, expTrunc[pendIdx]);
      end
      if (held) begin
        check(wrValid && wrMethod == hM && wrSubch == hS && wrValue == hV, "R10",
              "held write changed", {wrMethod, wrValue}, {hM, hV});
      end
      if (wrValid && wrReady) begin
        if (got < nExp) begin
          check(wrMethod == eMethod[got], eTag[got], "method", wrMethod, eMethod[got]);
          check(wrSubch == eSubch[got], "R2", "subchannel", wrSubch, eSubch[got]);
          check(wrValue == eValue[got], eTag[got], "value", wrValue, eValue[got]);
        end else begin
          check(0, "R7", "extra write", got, nExp);
        end
        got++;
      end
      held = wrValid && !wrReady;
      if (held) begin
        check(!wordReady, "R10", "wordReady during stall", wordReady, 0);
        hM = wrMethod; hS = wrSubch; hV = wrValue;
      end
      pendAcc = wordValid && wordReady;
      pendIdx = idx;
      @(posedge clk); #1;
      if (pendAcc) idx++;
      cyc++;
    end
    listStart = 1'b0; wordValid = 1'b0; wrReady = 1'b1;
    @(negedge clk);
    check(got == nExp, "R7", "write count", got, nExp);
    check(idx == len, "R7", "words consumed", idx, len);
    check(!busy && !wordReady, "R7", "idle after list", {busy, wordReady}, 0);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240601));
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!busy && !wordReady && !wrValid && !errBadMode && !errTrunc, "R1", "reset outputs",
          {busy, wordReady, wrValid, errBadMode, errTrunc}, 0);
    @(posedge clk); #1;

    // R7 zero length start leaves the block idle
    listStart = 1'b1; listLen = 16'd0;
    @(posedge clk); #1 listStart = 1'b0;
    @(negedge clk);
    check(!busy && !wordReady, "R7", "zero length list", {busy, wordReady}, 0);
    @(posedge clk); #1;

    // R3 increasing with method wrap, R2 field split
    mem[0] = mkHdr(1, 3, 5, 13'h1FFE); mem[1] = 32'hA0000001; mem[2] = 32'hA0000002;
    mem[3] = 32'hA0000003; mem[4] = mkHdr(0, 1, 2, 13'h0123); mem[5] = 32'hB0B0B0B0;
    runList(6, 100, 100, 0);
    runList(6, 70, 30, 0);

    // R4 non-increasing
    mem[0] = mkHdr(3, 3, 1, 13'h0400); mem[1] = 32'h11; mem[2] = 32'h22; mem[3] = 32'h33;
    mem[4] = mkHdr(2, 2, 6, 13'h1FFF); mem[5] = 32'h44; mem[6] = 32'h55;
    runList(7, 100, 100, 0);

    // R5 increase-once, count 0 case, then count 1
    mem[0] = mkHdr(5, 3, 4, 13'h1FFF); mem[1] = 32'hC1; mem[2] = 32'hC2; mem[3] = 32'hC3;
    mem[4] = mkHdr(5, 0, 4, 13'h0010); mem[5] = mkHdr(5, 1, 3, 13'h0020); mem[6] = 32'hC4;
    runList(7, 100, 100, 0);

    // R6 inline headers back to back, under back-pressure
    mem[0] = mkHdr(4, 13'h1ABC, 7, 13'h0055); mem[1] = mkHdr(4, 13'h1FFF, 0, 13'h1000);
    mem[2] = mkHdr(4, 0, 3, 13'h0001);
    runList(3, 100, 100, 0);
    runList(3, 100, 25, 0);

    // R8 bad modes then a normal header
    mem[0] = mkHdr(6, 2, 1, 13'h0100); mem[1] = mkHdr(7, 0, 2, 13'h0200);
    mem[2] = mkHdr(1, 1, 3, 13'h0300); mem[3] = 32'hDEADBEEF;
    runList(4, 100, 100, 0);

    // R9 truncation at list end, and a header that is the last word
    mem[0] = mkHdr(1, 5, 2, 13'h0700); mem[1] = 32'hE1; mem[2] = 32'hE2;
    runList(3, 100, 100, 0);
    mem[0] = mkHdr(4, 9, 1, 13'h0008); mem[1] = mkHdr(3, 2, 0, 13'h0009);
    runList(2, 100, 100, 0);

    // R7 start pulse during a list is ignored
    mem[0] = mkHdr(3, 6, 5, 13'h0042);
    for (int i = 1; i < 7; i++) mem[i] = 32'hF0 + i;
    runList(7, 60, 60, 1);

    // Random lists
    for (int n = 0; n < 40; n++) begin
      int len = 1 + ($urandom % 48);
      int pos = 0;
      while (pos < len) begin
        int cnt = $urandom % 6;
        mem[pos] = mkHdr($urandom % 8, cnt, $urandom % 8, $urandom % 8192);
        pos++;
        for (int a = 0; a < cnt && pos < len; a++) begin
          mem[pos] = $urandom;
          pos++;
        end
      end
      runList(len, 30 + ($urandom % 71), 20 + ($urandom % 81), 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule